// File: doc/BRIEF.md
# Interrupt and Trap Control Register

This block is a one-byte control and status register that sits beside an 8-bit processor's interrupt logic. The instruction decoder pulses a strobe when it fetches an opcode it cannot decode. A second signal with that strobe says which opcode byte was at fault. The register records the event in a sticky trap flag. It also keeps a position flag, which tells the handler how far back from the saved program counter the faulting instruction began.

The same byte holds one enable bit for each of three external interrupt lines. The block combines the raw external lines with these enables and with a global maskable-interrupt enable. Internal maskable sources are gated by the global enable alone. The non-maskable request and the trap request pass through with no gating.

Software reaches the register through a byte-wide I/O port decoded at one fixed address. Reads from any other address return zero. Writes to any other address change nothing.

Top module: `trapint_ctrl`

## Requirements
- R1: After reset, a read at address 0x34 returns 0x01. Bit 0 (enable for line 0) is 1, and every other bit is 0.
- R2: A cycle with `illop_stb` high sets the trap flag (read bit 7) to 1 from the next clock edge.
- R3: A write to 0x34 with bit 7 at 0 clears the trap flag. A write with bit 7 at 1 leaves the trap flag as it was, so software can never set it.
- R4: If `illop_stb` and a write that clears bit 7 fall in the same cycle, the trap flag is 1 afterwards.
- R5: Read bit 6 takes the value of `illop_third` on each `illop_stb` cycle. Here 0 means the instruction starts at saved PC minus 1, and 1 means saved PC minus 2. Writes never change bit 6, and it holds its value between strobes.
- R6: Read bits 5 to 3 are always 0, whatever was written to them.
- R7: A write to 0x34 loads bits 2 to 0 into the enables for external lines 2 to 0. A read returns them in the same positions.
- R8: Each `ext_irq_o[n]` equals `ext_irq_i[n]` AND enable n AND `gie`, combinationally.
- R9: Each `int_irq_o[k]` equals `int_irq_i[k]` AND `gie`, combinationally.
- R10: `nmi_o` follows `nmi_i`, and `trap_o` follows `illop_stb`, whatever the value of `gie` or the enables.
- R11: With the address not equal to 0x34, `io_rdata` is 0 and a write changes no register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0 when not addressed |
| illop_stb | input | 1 | Undefined-opcode strobe from the decoder |
| illop_third | input | 1 | 1: fault found on the third opcode byte, 0: on the second |
| gie | input | 1 | Global maskable-interrupt enable |
| ext_irq_i | input | 3 | Raw external interrupt lines |
| int_irq_i | input | 2 | Raw internal maskable sources |
| nmi_i | input | 1 | Raw non-maskable request |
| ext_irq_o | output | 3 | Masked external requests |
| int_irq_o | output | 2 | Masked internal requests |
| nmi_o | output | 1 | Non-maskable request, never gated |
| trap_o | output | 1 | Trap request, never gated |

## Verification
The bench drives a trap strobe and a clearing write in the same cycle. A design that let software win there would lose a trap. It writes ones to bit 7 with the flag clear, to catch a design that lets software raise a trap. It writes all ones to the byte, to catch bits 6 to 3 that can be written, or a position flag that moves without a strobe. Random traffic on nearby addresses and random `gie` and line values expose an address decode that is too loose, and gating that drops a term or gates NMI.

// File: rtl/trapint_pkg.sv
package trapint_pkg;
    localparam int NUM_EXT = 3;
    localparam int TRAP_BIT = 7;
    localparam int POS_BIT = 6;

    typedef struct packed {
        logic               trap;
        logic               pos;
        logic [NUM_EXT-1:0] en;
    } ctl_state_t;
endpackage

// File: rtl/trapint_decode.sv
module trapint_decode #(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h34
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    output logic              sel,
    output logic              wr_sel
);
    always_comb begin
        sel    = (io_addr == ADDR_W'(REG_ADDR));
        wr_sel = sel && io_wr;
    end
endmodule

// File: rtl/trapint_regfile.sv
module trapint_regfile
    import trapint_pkg::*;
#(
    parameter logic [NUM_EXT-1:0] EN_RST = 3'b001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr_sel,
    input  logic               wr_trap_bit,
    input  logic [NUM_EXT-1:0] wr_en_bits,
    input  logic               illop_stb,
    input  logic               illop_third,
    output logic [NUM_EXT-1:0] en_o,
    output logic [7:0]         rdata
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_sel) begin
            st_d.en = wr_en_bits;
            if (!wr_trap_bit)
                st_d.trap = 1'b0;
        end
        if (illop_stb) begin
            st_d.trap = 1'b1;
            st_d.pos  = illop_third;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.trap <= 1'b0;
            st_q.pos  <= 1'b0;
            st_q.en   <= EN_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata[TRAP_BIT]    = st_q.trap;
            rdata[POS_BIT]     = st_q.pos;
            rdata[NUM_EXT-1:0] = st_q.en;
        end
    end

    assign en_o = st_q.en;

    // R2
    trap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illop_stb |=> st_q.trap);
    // R3
    no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!illop_stb && !st_q.trap) |=> !st_q.trap);
    // R3
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !wr_trap_bit && !illop_stb) |=> !st_q.trap);
    // R5
    pos_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illop_stb |=> (st_q.pos == $past(illop_third)));
    // R5
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !illop_stb |=> $stable(st_q.pos));
    // R11
    no_sel_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata == 8'h00));
endmodule

// File: rtl/trapint_gate.sv
module trapint_gate #(
    parameter int NUM_EXT = 3,
    parameter int NUM_INT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gie,
    input  logic [NUM_EXT-1:0] en,
    input  logic [NUM_EXT-1:0] ext_irq_i,
    input  logic [NUM_INT-1:0] int_irq_i,
    output logic [NUM_EXT-1:0] ext_irq_o,
    output logic [NUM_INT-1:0] int_irq_o
);
    for (genvar n = 0; n < NUM_EXT; n++) begin : g_ext
        assign ext_irq_o[n] = ext_irq_i[n] & en[n] & gie;
    end
    for (genvar k = 0; k < NUM_INT; k++) begin : g_int
        assign int_irq_o[k] = int_irq_i[k] & gie;
    end

    // R8
    gie_mask_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (ext_irq_o == '0));
    // R9
    gie_mask_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (int_irq_o == '0));
    // R8
    lane_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ext_irq_o & ~(ext_irq_i & en)) == '0));
endmodule

// File: rtl/trapint_ctrl.sv
module trapint_ctrl
    import trapint_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] REG_ADDR = 8'h34,
    parameter int         NUM_INT  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    input  logic               illop_stb,
    input  logic               illop_third,
    input  logic               gie,
    input  logic [NUM_EXT-1:0] ext_irq_i,
    input  logic [NUM_INT-1:0] int_irq_i,
    input  logic               nmi_i,
    output logic [NUM_EXT-1:0] ext_irq_o,
    output logic [NUM_INT-1:0] int_irq_o,
    output logic               nmi_o,
    output logic               trap_o
);
    logic               sel, wr_sel;
    logic [NUM_EXT-1:0] en;
    logic               unused_wbits;

    assign unused_wbits = ^io_wdata[POS_BIT:NUM_EXT];

    trapint_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .sel     (sel),
        .wr_sel  (wr_sel)
    );

    trapint_regfile u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .wr_sel      (wr_sel),
        .wr_trap_bit (io_wdata[TRAP_BIT]),
        .wr_en_bits  (io_wdata[NUM_EXT-1:0]),
        .illop_stb   (illop_stb),
        .illop_third (illop_third),
        .en_o        (en),
        .rdata       (io_rdata)
    );

    trapint_gate #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gie       (gie),
        .en        (en),
        .ext_irq_i (ext_irq_i),
        .int_irq_i (int_irq_i),
        .ext_irq_o (ext_irq_o),
        .int_irq_o (int_irq_o)
    );

    assign nmi_o  = nmi_i;
    assign trap_o = illop_stb;

    // R10
    nmi_ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie && nmi_i) |-> nmi_o);
    // R6
    unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rdata[5:3] == 3'b000));
endmodule

// File: tb/sim_trapint_ctrl.sv
module sim_trapint_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       illop_stb = 1'b0;
    logic       illop_third = 1'b0;
    logic       gie = 1'b0;
    logic [2:0] ext_irq_i = 3'b000;
    logic [1:0] int_irq_i = 2'b00;
    logic       nmi_i = 1'b0;
    logic [2:0] ext_irq_o;
    logic [1:0] int_irq_o;
    logic       nmi_o, trap_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model of the register
    logic       m_trap = 1'b0, m_pos = 1'b0;
    logic [2:0] m_en = 3'b001;

    always #10 clk = ~clk;

    trapint_ctrl u0 (.*);

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        return (a == 8'h34) ? {m_trap, m_pos, 3'b000, m_en} : 8'h00;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // check every output against the model for the inputs now applied
    task automatic check_all();
        check("R1/R6/R7/R11 rdata", io_rdata, exp_rd(io_addr));
        check("R8 ext_irq_o", ext_irq_o, ext_irq_i & m_en & {3{gie}});
        check("R9 int_irq_o", int_irq_o, int_irq_i & {2{gie}});
        check("R10 nmi/trap", {nmi_o, trap_o}, {nmi_i, illop_stb});
    endtask

    // commit one clock edge into the model
    task automatic step();
        logic hit;
        hit = io_wr && (io_addr == 8'h34);
        @(posedge clk);
        if (hit) begin
            m_en = io_wdata[2:0];
            if (!io_wdata[7]) m_trap = 1'b0;
        end
        if (illop_stb) begin
            m_trap = 1'b1;
            m_pos  = illop_third;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        io_wr = 1'b0; illop_stb = 1'b0; io_addr = 8'h34;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        io_addr = 8'h34; #1;
        check("R1 reset value", io_rdata, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: writing 1 to bit 7 with the flag clear does not set it
        io_wr = 1'b1; io_wdata = 8'hFF; step(); idle(); #1;
        check("R3 no software set", io_rdata[7], 1'b0);
        check("R6 unused bits read zero", io_rdata[5:3], 3'b000);
        check("R5 pos not writable", io_rdata[6], 1'b0);
        check("R7 enables loaded", io_rdata[2:0], 3'b111);

        // R2 + R5: trap on third byte
        illop_stb = 1'b1; illop_third = 1'b1; #1;
        check("R10 trap passes", trap_o, 1'b1);
        step(); idle(); #1;
        check("R2 trap set", io_rdata[7], 1'b1);
        check("R5 pos captured third", io_rdata[6], 1'b1);

        // R3: writing 1 keeps it set; R5 write 0 to bit 6 ignored
        io_wr = 1'b1; io_wdata = 8'h80; step(); idle(); #1;
        check("R3 write one keeps trap", io_rdata[7], 1'b1);
        check("R5 pos held over write", io_rdata[6], 1'b1);

        // R4: strobe and clear in the same cycle
        io_wr = 1'b1; io_wdata = 8'h02; illop_stb = 1'b1; illop_third = 1'b0;
        step(); idle(); #1;
        check("R4 set wins over clear", io_rdata, 8'h82);

        // R3: plain clear
        io_wr = 1'b1; io_wdata = 8'h05; step(); idle(); #1;
        check("R3 clear trap", io_rdata, 8'h05);

        // R11: write elsewhere ignored
        io_addr = 8'h35; io_wr = 1'b1; io_wdata = 8'h00; #1;
        check("R11 other address reads zero", io_rdata, 8'h00);
        step(); idle(); #1;
        check("R11 other address write ignored", io_rdata, 8'h05);

        // R10: NMI with gie low
        gie = 1'b0; nmi_i = 1'b1; ext_irq_i = 3'b111; int_irq_i = 2'b11; #1;
        check("R10 nmi ungated", nmi_o, 1'b1);
        check("R8 gie masks ext", ext_irq_o, 3'b000);
        gie = 1'b1; #1;
        check("R8 enables mask ext", ext_irq_o, 3'b101);
        check("R9 internal pass", int_irq_o, 2'b11);

        // random traffic
        for (int i = 0; i < 2000; i++) begin
            io_addr     = ($urandom_range(0, 1) == 0) ? 8'h34 : 8'(8'h30 + $urandom_range(0, 7));
            io_wr       = ($urandom_range(0, 2) == 0);
            io_wdata    = 8'($urandom);
            illop_stb   = ($urandom_range(0, 6) == 0);
            illop_third = 1'($urandom);
            gie         = 1'($urandom);
            ext_irq_i   = 3'($urandom);
            int_irq_i   = 2'($urandom);
            nmi_i       = 1'($urandom);
            #1;
            check_all();
            step();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule